// File: doc/BRIEF.md
# Phase-Mode Numerically Controlled Oscillator

This core is a numerically controlled oscillator. A 32-bit phase accumulator advances by an active tuning word on every clock. The registered phase output is the accumulator plus a 14-bit phase offset, with the offset placed in the top bits (offset in turns times 2^14). The output frequency is the tuning word times the clock rate divided by 2^32. A 64-bit timestamp counter counts clocks from reset.

Software loads a new tuning word and offset one byte at a time into shadow registers. Nothing visible changes until an update strobe copies the shadow values into the active registers. A control byte selects what the strobe does to the accumulator. In continuous mode the accumulator is left alone, so the only phase jump comes from the offset. In absolute mode the accumulator is cleared, so the output phase right after the update equals the offset. In tracking mode the accumulator is preset to the value it would hold had the new tuning word been running since the timestamp was zero.

Top module: `nco_phase_core`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the shadow and active registers, the timestamp and the mode. The first clock edge with reset low then sees `phase_out` = 0, `time_now` = 0 and continuous mode.
- R2: On every clock edge without a strobe, the accumulator adds the active tuning word, modulo 2^32. After every edge, `phase_out` equals the accumulator plus (active offset << 18), modulo 2^32.
- R3: The tuning word is written at addresses 0x0A, 0x0B, 0x0C and 0x0D, holding bits 7:0, 15:8, 23:16 and 31:24 in that order. Offset bits 7:0 are written at 0x0E. Offset bits 13:8 are written at 0x0F from `wr_data[5:0]`, and `wr_data[7:6]` is dropped.
- R4: A write changes only a shadow register. Without a strobe, `phase_out` keeps following the active values.
- R5: Continuous mode: on the strobe edge the accumulator still adds the old active tuning word. The new tuning word and offset are used from that edge on.
- R6: Absolute mode: on the strobe edge the accumulator becomes 0, so `phase_out` equals the new offset << 18.
- R7: Tracking mode: on the strobe edge the accumulator becomes the new tuning word times `time_now` as seen after that edge, modulo 2^32. While the tuning word is unchanged, this relation then holds on every later cycle.
- R8: The control byte at address 0x02 sets the mode. Bit 6 enables clearing at updates. Bit 7 selects tracking and counts only when bit 6 is set. So 0x00 or 0x80 gives continuous, 0x40 gives absolute and 0xC0 gives tracking. The mode takes effect from the next strobe.
- R9: A write to any address other than 0x02 and 0x0A to 0x0F changes no shadow register and does not change the mode.
- R10: If a write and a strobe fall on the same edge, the strobe applies the shadow contents from before that write. The written value takes effect only at the next strobe.
- R11: `time_now` increases by exactly one on every clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data byte |
| upd_stb | input | 1 | Update strobe: copy shadow to active and apply the phase mode |
| phase_out | output | 32 | Registered phase: accumulator plus shifted offset |
| time_now | output | 64 | Free-running timestamp counter |

## Verification
A corrupted accumulator or active tuning word shows on `phase_out` within one clock. The output is registered against the next state, so the step between two consecutive samples exposes the active tuning word directly. A wrong mode is visible on the edge that follows the strobe: absolute mode must show exactly the shifted offset, and tracking mode must match tuning word times `time_now`. A shadow register that leaks early, or a write that is decoded wrongly, is caught as a wrong phase step on the edge after the strobe. Writes to ignored addresses are checked at the ports by strobing after them and checking that both the phase step and the mode are unchanged.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    MODE_CONT  = 2'd0,
    MODE_ABS   = 2'd1,
    MODE_TRACK = 2'd2
  } phase_mode_e;

  localparam logic [7:0] ADR_CTRL = 8'h02;
  localparam logic [7:0] ADR_FTW0 = 8'h0A;
  localparam logic [7:0] ADR_OFF0 = 8'h0E;
  localparam int CTRL_CLR_BIT = 6;
  localparam int CTRL_TRK_BIT = 7;

  function automatic phase_mode_e decode_mode(input logic clr_en, input logic trk_sel);
    if (!clr_en)     return MODE_CONT;
    else if (trk_sel) return MODE_TRACK;
    else             return MODE_ABS;
  endfunction
endpackage

// File: rtl/nco_timebase.sv
module nco_timebase #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] ts_q
);
  always_ff @(posedge clk) begin
    if (rst) ts_q <= '0;
    else     ts_q <= ts_q + TS_W'(1);
  end

  // R11: one step per clock
  p_ts_step_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ts_q == $past(ts_q) + TS_W'(1));
endmodule

// File: rtl/nco_regfile.sv
module nco_regfile
  import nco_pkg::*;
#(
  parameter int ACC_W  = 32,
  parameter int OFF_W  = 14,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              upd,
  output logic [ACC_W-1:0]  ftw_sh,
  output logic [OFF_W-1:0]  off_sh,
  output logic [ACC_W-1:0]  ftw_act,
  output logic [OFF_W-1:0]  off_act,
  output phase_mode_e       mode
);
  localparam int FTW_BYTES = ACC_W / 8;
  localparam int OFF_BYTES = (OFF_W + 7) / 8;

  // R3: one shadow byte per address, least significant first
  for (genvar i = 0; i < FTW_BYTES; i++) begin : g_ftw
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (rst) b_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(ADR_FTW0) + ADDR_W'(i)) b_q <= wr_data;
    end
    assign ftw_sh[8*i +: 8] = b_q;
  end

  for (genvar j = 0; j < OFF_BYTES; j++) begin : g_off
    localparam int BW = (OFF_W - 8*j > 8) ? 8 : OFF_W - 8*j;
    logic [BW-1:0] b_q;
    always_ff @(posedge clk) begin
      if (rst) b_q <= '0;
      else if (wr_en && wr_addr == ADDR_W'(ADR_OFF0) + ADDR_W'(j)) b_q <= wr_data[BW-1:0];
    end
    assign off_sh[8*j +: BW] = b_q;
  end

  // R8: mode is a plain control register sampled at the next strobe
  always_ff @(posedge clk) begin
    if (rst) mode <= MODE_CONT;
    else if (wr_en && wr_addr == ADDR_W'(ADR_CTRL))
      mode <= decode_mode(wr_data[CTRL_CLR_BIT], wr_data[CTRL_TRK_BIT]);
  end

  // R4/R10: active copy taken from the shadow as it stood before this edge
  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_act <= '0;
      off_act <= '0;
    end else if (upd) begin
      ftw_act <= ftw_sh;
      off_act <= off_sh;
    end
  end

  logic addr_mapped;
  always_comb begin
    addr_mapped = (wr_addr == ADDR_W'(ADR_CTRL))
               || (wr_addr >= ADDR_W'(ADR_FTW0) && wr_addr < ADDR_W'(ADR_FTW0) + ADDR_W'(FTW_BYTES))
               || (wr_addr >= ADDR_W'(ADR_OFF0) && wr_addr < ADDR_W'(ADR_OFF0) + ADDR_W'(OFF_BYTES));
  end

  // R4: active values move only on a strobe
  p_hold_active_r4: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(ftw_act) && $stable(off_act));

  // R9: unmapped writes leave all state alone
  p_ignore_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_mapped) |=> $stable(ftw_sh) && $stable(off_sh) && $stable(mode));
endmodule

// File: rtl/nco_accum.sv
module nco_accum
  import nco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OFF_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  phase_mode_e      mode,
  input  logic [ACC_W-1:0] ftw_act,
  input  logic [ACC_W-1:0] ftw_sh,
  input  logic [OFF_W-1:0] off_act,
  input  logic [OFF_W-1:0] off_sh,
  input  logic [ACC_W-1:0] ts_lo,
  output logic [ACC_W-1:0] phase_q
);
  localparam int PAD_W = ACC_W - OFF_W;

  logic [ACC_W-1:0] acc_q, acc_d, ts_next, phase_d;
  logic [OFF_W-1:0] off_d;

  assign ts_next = ts_lo + ACC_W'(1);

  always_comb begin
    acc_d = acc_q + ftw_act;
    if (upd) begin
      unique case (mode)
        MODE_ABS:   acc_d = '0;
        MODE_TRACK: acc_d = ftw_sh * ts_next;
        default:    acc_d = acc_q + ftw_act;
      endcase
    end
    off_d   = upd ? off_sh : off_act;
    phase_d = acc_d + {off_d, {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      phase_q <= '0;
    end else begin
      acc_q   <= acc_d;
      phase_q <= phase_d;
    end
  end

  // R2: output equals accumulator plus shifted active offset
  p_phase_sum_r2: assert property (@(posedge clk) disable iff (rst)
    phase_q == acc_q + {off_act, {PAD_W{1'b0}}});

  // R5: continuous update keeps the running accumulator
  p_cont_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == MODE_CONT) |=> acc_q == $past(acc_q) + $past(ftw_act));

  // R6: absolute update clears the accumulator
  p_abs_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == MODE_ABS) |=> acc_q == '0);

  // R7: tracking update lines up with the timestamp
  p_track_align_r7: assert property (@(posedge clk) disable iff (rst)
    (upd && mode == MODE_TRACK) |=> acc_q == $past(ftw_sh) * ts_lo);
endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core #(
  parameter int ACC_W  = 32,
  parameter int OFF_W  = 14,
  parameter int TS_W   = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              upd_stb,
  output logic [ACC_W-1:0]  phase_out,
  output logic [TS_W-1:0]   time_now
);
  logic [ACC_W-1:0] ftw_sh, ftw_act;
  logic [OFF_W-1:0] off_sh, off_act;
  nco_pkg::phase_mode_e mode;

  nco_timebase #(.TS_W(TS_W)) u_time (
    .clk  (clk),
    .rst  (rst),
    .ts_q (time_now)
  );

  nco_regfile #(.ACC_W(ACC_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .upd     (upd_stb),
    .ftw_sh  (ftw_sh),
    .off_sh  (off_sh),
    .ftw_act (ftw_act),
    .off_act (off_act),
    .mode    (mode)
  );

  nco_accum #(.ACC_W(ACC_W), .OFF_W(OFF_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .upd     (upd_stb),
    .mode    (mode),
    .ftw_act (ftw_act),
    .ftw_sh  (ftw_sh),
    .off_act (off_act),
    .off_sh  (off_sh),
    .ts_lo   (time_now[ACC_W-1:0]),
    .phase_q (phase_out)
  );

  // R1: reset leaves phase and timestamp at zero
  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (phase_out == '0 && time_now == '0));
endmodule

// File: tb/nco_phase_core_tb_top.sv
`timescale 1ns/1ps
module nco_phase_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        upd_stb = 1'b0;
  logic [31:0] phase_out;
  logic [63:0] time_now;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nco_phase_core dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd_stb(upd_stb),
    .phase_out(phase_out), .time_now(time_now)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    upd_stb = 1'b1;
    @(negedge clk);
    upd_stb = 1'b0;
  endtask

  task automatic wr_ftw(input logic [31:0] f);
    for (int i = 0; i < 4; i++) wr(8'h0A + 8'(i), f[8*i +: 8]);
  endtask

  task automatic t_reset();
    check("R1 phase after reset", 64'(phase_out), 64'h0);
    check("R1 time after reset", time_now, 64'h0);
  endtask

  task automatic t_timestamp();
    logic [63:0] t0;
    t0 = time_now;
    idle(7);
    check("R11 timestamp step", time_now, t0 + 64'd7);
  endtask

  task automatic t_shadow_cont();
    wr_ftw(32'h0000_1000);
    check("R4 shadow write hidden", 64'(phase_out), 64'h0);
    strobe();
    check("R5 continuous keeps acc", 64'(phase_out), 64'h0);
    idle(3);
    check("R2 advance by tuning word", 64'(phase_out), 64'h3000);
  endtask

  task automatic t_offset_cont();
    logic [31:0] p;
    wr(8'h0E, 8'h01);
    wr(8'h0F, 8'h00);
    p = phase_out;
    strobe();
    check("R5 offset-only jump", 64'(phase_out), 64'(p + 32'h1000 + 32'h0004_0000));
  endtask

  task automatic t_absolute();
    wr(8'h02, 8'h40);
    wr_ftw(32'h1122_3344);
    wr(8'h0E, 8'hAB);
    wr(8'h0F, 8'hFF);
    strobe();
    check("R6 absolute clears to offset", 64'(phase_out), 64'hFEAC_0000);
    idle(1);
    check("R3 byte order and offset mask", 64'(phase_out), 64'h0FCE_3344);
  endtask

  task automatic t_tracking();
    logic [31:0] e;
    wr(8'h02, 8'hC0);
    wr_ftw(32'h0001_0001);
    strobe();
    e = 32'h0001_0001 * time_now[31:0] + 32'hFEAC_0000;
    check("R7 tracking preset", 64'(phase_out), 64'(e));
    idle(4);
    e = 32'h0001_0001 * time_now[31:0] + 32'hFEAC_0000;
    check("R7 tracking holds", 64'(phase_out), 64'(e));
  endtask

  task automatic t_track_bit_alone();
    logic [31:0] p;
    wr(8'h02, 8'h80);
    wr_ftw(32'h0000_0100);
    p = phase_out;
    strobe();
    check("R8 bit7 alone is continuous", 64'(phase_out), 64'(p + 32'h0001_0001));
    idle(1);
    check("R8 new word after update", 64'(phase_out), 64'(p + 32'h0001_0101));
  endtask

  task automatic t_ignored();
    logic [31:0] p;
    wr(8'h03, 8'h40);
    wr(8'h00, 8'hC0);
    wr(8'h09, 8'hFF);
    wr(8'h10, 8'hFF);
    wr(8'h20, 8'h55);
    p = phase_out;
    strobe();
    check("R9 mode untouched", 64'(phase_out), 64'(p + 32'h100));
    idle(1);
    check("R9 shadow untouched", 64'(phase_out), 64'(p + 32'h200));
  endtask

  task automatic t_same_cycle();
    logic [31:0] p;
    p = phase_out;
    wr_en = 1'b1; wr_addr = 8'h0B; wr_data = 8'h02; upd_stb = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; upd_stb = 1'b0;
    check("R10 strobe uses old shadow", 64'(phase_out), 64'(p + 32'h100));
    idle(1);
    check("R10 write not yet active", 64'(phase_out), 64'(p + 32'h200));
    p = phase_out;
    strobe();
    idle(1);
    check("R10 applied at next strobe", 64'(phase_out), 64'(p + 32'h100 + 32'h200));
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    t_reset();
    t_timestamp();
    t_shadow_cont();
    t_offset_cont();
    t_absolute();
    t_tracking();
    t_track_bit_alone();
    t_ignored();
    t_same_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule